// File: doc/BRIEF.md
# Ethernet Flow Control Frame Generator

This block makes the flow-control traffic of an Ethernet MAC. An application raises a request when its receive buffers run low. In full-duplex operation the block answers by producing an 802.3x pause frame as a byte stream, which a transmit framer consumes through a valid/ready handshake. When the request is withdrawn, the block follows up with a pause frame whose pause time is zero, so the link partner resumes at once. In half-duplex operation no frames are made. Instead, a backpressure request is raised for the transmitter, which jams the medium.

While the request is held, the block can refresh the pause by sending a new frame after a programmable number of slot times. Each slot time is 64 byte clocks. On the receive side, the block watches the header bytes of every incoming frame. When a frame is a pause frame, it strobes the pause time out to the application. The frame itself is not consumed.

The stream covers destination address through padding. The framer appends the CRC.

Top module: `fc_frame_gen`

## Requirements
- R1: A pause frame is exactly 60 bytes, in this order:
  - bytes 0-5: 01 80 C2 00 00 01
  - bytes 6-11: `station_mac`, most significant byte first
  - bytes 12-13: 88 08
  - bytes 14-15: 00 01
  - bytes 16-17: the pause time, high byte first
  - bytes 18-59: zero

  `tx_last` is high only on byte 59. At least one idle cycle follows each frame.
- R2: In full duplex, a rising `fc_req` produces one frame carrying `pause_quanta`.
- R3: In full duplex, a falling `fc_req` produces one frame with pause time zero. It is sent only after any earlier pause frame has been sent.
- R4: While `fc_req` stays high in full duplex and `refresh_slots` is N > 0, a new `pause_quanta` frame is queued every N×64 cycles, counted from the rising edge.
- R5: Suppose a fall is followed by a new rise before the zero-time frame has started. The zero-time frame is then cancelled. A pending request is never duplicated.
- R6: In half duplex, `bp_req` follows `fc_req` and no frame is produced. In full duplex, `bp_req` stays low.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold.
- R8: Received frames are matched on:
  - destination address 01-80-C2-00-00-01
  - type 88 08
  - opcode 00 01

  Any source address is accepted. Byte 0 is marked by `rx_sof`. One cycle after byte 17 is accepted, `rx_pause_valid` pulses for one cycle and `rx_pause_time` holds bytes 16-17.
- R9: A received frame that differs in any matched byte gives no strobe.
- R10: After reset, `tx_valid`, `bp_req` and `rx_pause_valid` are low.
- R11: With `refresh_slots` = 0, a held request produces no further frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| fc_req | input | 1 | application flow-control request |
| full_dup | input | 1 | 1 = full duplex, 0 = half duplex |
| station_mac | input | 48 | own MAC address, used as the source address |
| pause_quanta | input | 16 | pause time for non-zero frames |
| refresh_slots | input | 16 | refresh interval in slot times, 0 = off |
| tx_valid | output | 1 | a frame byte is offered |
| tx_data | output | 8 | frame byte |
| tx_last | output | 1 | last byte of the frame |
| tx_ready | input | 1 | framer accepts the byte |
| bp_req | output | 1 | half-duplex backpressure request |
| rx_valid | input | 1 | received byte valid |
| rx_sof | input | 1 | received byte is the first of a frame |
| rx_data | input | 8 | received byte |
| rx_pause_valid | output | 1 | pause frame detected, one-cycle strobe |
| rx_pause_time | output | 16 | received pause time |

## Verification
A request edge can arrive while a frame is already being streamed. In that case queueing and transmission act in the same cycle. The bench stalls the framer mid-frame and toggles the request down and up during the stall. It then judges the case by the exact list of frames that follow: two frames carrying the quanta, and no zero-time frame. A one-cycle request pulse makes the fall coincide with the start of the first frame. The bench requires the non-zero frame to come before the zero-time one.

// File: rtl/fc_frame_gen.sv
module fc_frame_gen #(
  parameter int SLOT_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fc_req,
  input  logic        full_dup,
  input  logic [47:0] station_mac,
  input  logic [15:0] pause_quanta,
  input  logic [15:0] refresh_slots,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready,
  output logic        bp_req,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic [7:0]  rx_data,
  output logic        rx_pause_valid,
  output logic [15:0] rx_pause_time
);
  localparam int FRAME_BYTES = 60;
  localparam int IW = $clog2(FRAME_BYTES);
  localparam int SW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BYTES - 1);
  localparam logic [SW-1:0] SLOT_END = SW'(SLOT_CYCLES - 1);
  localparam logic [4:0] RX_IDLE = 5'd18;

  function automatic logic [8:0] hdr_const(input logic [4:0] pos);
    case (pos)
      5'd0, 5'd5:  hdr_const = 9'h101;
      5'd1:        hdr_const = 9'h180;
      5'd2:        hdr_const = 9'h1C2;
      5'd3, 5'd4:  hdr_const = 9'h100;
      5'd12:       hdr_const = 9'h188;
      5'd13:       hdr_const = 9'h108;
      5'd14:       hdr_const = 9'h100;
      5'd15:       hdr_const = 9'h101;
      default:     hdr_const = 9'h000;
    endcase
  endfunction

  logic          req_q, busy, pend_on, pend_off;
  logic [IW-1:0] idx;
  logic [15:0]   cur_time;
  logic [SW-1:0] slot_cnt;
  logic [15:0]   n_slots;

  wire rise    = fc_req & ~req_q;
  wire fall    = ~fc_req & req_q;
  wire rf_act  = fc_req & full_dup & (refresh_slots != 16'd0);
  wire rf_hit  = rf_act & ~rise & (slot_cnt == SLOT_END) & (n_slots == refresh_slots - 16'd1);
  wire set_on  = full_dup & (rise | rf_hit);
  wire set_off = full_dup & fall;
  wire start   = ~busy & (pend_on | pend_off);

  assign bp_req   = fc_req & ~full_dup;
  assign tx_valid = busy;
  assign tx_last  = busy & (idx == LAST_IDX);

  always_comb begin
    tx_data = 8'h00;
    if (idx < IW'(16)) begin
      if (hdr_const(idx[4:0]) & 9'h100) tx_data = hdr_const(idx[4:0])[7:0];
    end
    case (idx)
      IW'(6):  tx_data = station_mac[47:40];
      IW'(7):  tx_data = station_mac[39:32];
      IW'(8):  tx_data = station_mac[31:24];
      IW'(9):  tx_data = station_mac[23:16];
      IW'(10): tx_data = station_mac[15:8];
      IW'(11): tx_data = station_mac[7:0];
      IW'(16): tx_data = cur_time[15:8];
      IW'(17): tx_data = cur_time[7:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0; busy <= 1'b0; idx <= '0; cur_time <= '0;
      pend_on <= 1'b0; pend_off <= 1'b0; slot_cnt <= '0; n_slots <= '0;
    end else begin
      req_q <= fc_req;
      if (start) begin
        busy     <= 1'b1;
        idx      <= '0;
        cur_time <= pend_on ? pause_quanta : 16'h0000;
      end else if (busy && tx_ready) begin
        if (idx == LAST_IDX) busy <= 1'b0;
        else idx <= idx + 1'b1;
      end
      pend_on <= (pend_on & ~(start & pend_on)) | set_on;
      if (set_off)      pend_off <= 1'b1;
      else if (set_on)  pend_off <= 1'b0;
      else if (start && !pend_on) pend_off <= 1'b0;
      if (!rf_act || rise || rf_hit) begin
        slot_cnt <= '0; n_slots <= '0;
      end else if (slot_cnt == SLOT_END) begin
        slot_cnt <= '0; n_slots <= n_slots + 16'd1;
      end else begin
        slot_cnt <= slot_cnt + 1'b1;
      end
    end
  end

  logic [4:0] rx_pos_q;
  logic       rx_hit_q;
  logic [7:0] rx_hi_q;
  wire [4:0]  rx_pos  = rx_sof ? 5'd0 : rx_pos_q;
  wire [8:0]  rx_exp  = hdr_const(rx_pos);
  wire        rx_ok   = ~rx_exp[8] | (rx_data == rx_exp[7:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_pos_q <= RX_IDLE; rx_hit_q <= 1'b0; rx_hi_q <= '0;
      rx_pause_valid <= 1'b0; rx_pause_time <= '0;
    end else begin
      rx_pause_valid <= 1'b0;
      if (rx_valid) begin
        rx_pos_q <= (rx_pos == RX_IDLE) ? RX_IDLE : rx_pos + 5'd1;
        rx_hit_q <= ((rx_pos == 5'd0) | rx_hit_q) & rx_ok;
        if (rx_pos == 5'd16) rx_hi_q <= rx_data;
        if (rx_pos == 5'd17 && rx_hit_q) begin
          rx_pause_valid <= 1'b1;
          rx_pause_time  <= {rx_hi_q, rx_data};
        end
      end
    end
  end
endmodule

// File: rtl/fc_frame_gen_chk.sv
module fc_frame_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       full_dup,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_last,
  input logic       tx_ready,
  input logic       bp_req,
  input logic       rx_valid,
  input logic       rx_pause_valid
);
  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  // R1
  first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_data == 8'h01);
  // R1
  frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> !tx_valid);
  // R6
  bp_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req |-> !full_dup);
  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pause_valid |=> !rx_pause_valid);
  // R8
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pause_valid |-> $past(rx_valid));
endmodule

bind fc_frame_gen fc_frame_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .full_dup(full_dup), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready), .bp_req(bp_req),
  .rx_valid(rx_valid), .rx_pause_valid(rx_pause_valid)
);

// File: tb/fc_frame_gen_tb.sv
module fc_frame_gen_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fc_req = 0, full_dup = 1, tx_ready = 1, rx_valid = 0, rx_sof = 0;
  logic [47:0] station_mac = 48'h02_11_22_33_44_55;
  logic [15:0] pause_quanta = 16'h1234, refresh_slots = 16'd0;
  logic [7:0]  rx_data = 8'h00;
  logic tx_valid, tx_last, bp_req, rx_pause_valid;
  logic [7:0] tx_data;
  logic [15:0] rx_pause_time;
  int total = 0, bad = 0, cyc = 0;

  fc_frame_gen u_dut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // {corrupt_pos, xor_mask, pause_time, 7'b0, expect_strobe}
  localparam logic [39:0] RX_VEC [6] = '{
    {8'hFF, 8'h00, 16'h1234, 8'h01},
    {8'h07, 8'h5A, 16'hFFFF, 8'h01},
    {8'h00, 8'h01, 16'h0001, 8'h00},
    {8'h0D, 8'h01, 16'h0040, 8'h00},
    {8'h0F, 8'h02, 16'h0050, 8'h00},
    {8'hFF, 8'h00, 16'h0000, 8'h01}
  };

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] frame_byte(input int i, input logic [15:0] t);
    logic [7:0] b;
    case (i)
      0: b = 8'h01;  1: b = 8'h80;  2: b = 8'hC2;
      3: b = 8'h00;  4: b = 8'h00;  5: b = 8'h01;
      6: b = station_mac[47:40];  7: b = station_mac[39:32];
      8: b = station_mac[31:24];  9: b = station_mac[23:16];
      10: b = station_mac[15:8];  11: b = station_mac[7:0];
      12: b = 8'h88; 13: b = 8'h08; 14: b = 8'h00; 15: b = 8'h01;
      16: b = t[15:8]; 17: b = t[7:0];
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  task automatic expect_frame(input logic [15:0] t, input string tag, output int start_cyc);
    int wait_n = 0;
    int errs = 0;
    logic [15:0] got;
    while (!tx_valid && wait_n < 400) begin @(negedge clk); wait_n++; end
    start_cyc = cyc;
    chk(tx_valid, {tag, " frame appears"}, 32'(tx_valid), 1);
    for (int i = 0; i < 60; i++) begin
      if (!tx_valid || tx_data != frame_byte(i, t) || tx_last != (i == 59)) errs++;
      if (i == 16) got[15:8] = tx_data;
      if (i == 17) got[7:0] = tx_data;
      @(negedge clk);
    end
    chk(errs == 0, "R1 frame layout", 32'(errs), 0);
    chk(got == t, {tag, " pause time"}, 32'(got), 32'(t));
  endtask

  task automatic no_frame(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      if (tx_valid) seen++;
      @(negedge clk);
    end
    chk(seen == 0, {tag, " no frame"}, 32'(seen), 0);
  endtask

  task automatic rx_frame(input logic [39:0] v);
    logic [7:0] b;
    for (int i = 0; i < 20; i++) begin
      b = frame_byte(i, v[23:8]);
      if (i == int'(v[39:32])) b = b ^ v[31:24];
      rx_valid = 1; rx_sof = (i == 0); rx_data = b;
      @(negedge clk);
      if (i == 17) begin
        chk(rx_pause_valid == v[0], "R8 R9 strobe", 32'(rx_pause_valid), 32'(v[0]));
        if (v[0]) chk(rx_pause_time == v[23:8], "R8 time", 32'(rx_pause_time), 32'(v[23:8]));
      end else begin
        chk(!rx_pause_valid, "R8 strobe only after byte 17", 32'(rx_pause_valid), 0);
      end
    end
    rx_valid = 0; rx_sof = 0;
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int c0, c1, c2;
    repeat (3) @(negedge clk);
    chk(!tx_valid && !bp_req && !rx_pause_valid, "R10 reset outputs",
        {29'd0, tx_valid, bp_req, rx_pause_valid}, 0);
    rst_n = 1;
    @(negedge clk);

    // receive table
    foreach (RX_VEC[k]) begin
      rx_frame(RX_VEC[k]);
      @(negedge clk);
    end

    // R2 R11: request in full duplex, no refresh
    fc_req = 1;
    expect_frame(16'h1234, "R2", c0);
    no_frame(300, "R11");
    // R3: release
    fc_req = 0;
    expect_frame(16'h0000, "R3", c0);
    no_frame(100, "R3 single zero");

    // R3 ordering: one-cycle pulse
    fc_req = 1; @(negedge clk); fc_req = 0;
    expect_frame(16'h1234, "R3 pulse first", c0);
    expect_frame(16'h0000, "R3 pulse zero second", c0);
    no_frame(100, "R3 pulse");

    // R7 stall, R5 fall+rise while a frame is streaming
    pause_quanta = 16'h00AB;
    tx_ready = 0;
    fc_req = 1;
    c1 = 0;
    while (!tx_valid && c1 < 20) begin @(negedge clk); c1++; end
    begin
      logic [7:0] d0;
      int moved = 0;
      d0 = tx_data;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (!tx_valid || tx_data != d0) moved++;
      end
      chk(moved == 0, "R7 hold under stall", 32'(moved), 0);
    end
    fc_req = 0; @(negedge clk);
    fc_req = 1; @(negedge clk);
    tx_ready = 1;
    expect_frame(16'h00AB, "R5 stalled", c0);
    expect_frame(16'h00AB, "R5 requeued", c0);
    no_frame(150, "R5 zero cancelled");
    fc_req = 0;
    expect_frame(16'h0000, "R3 after R5", c0);

    // R4 refresh
    pause_quanta = 16'h0777;
    refresh_slots = 16'd2;
    c0 = cyc;
    fc_req = 1;
    expect_frame(16'h0777, "R4 first", c1);
    expect_frame(16'h0777, "R4 refresh", c2);
    chk((c2 - c0) >= 125 && (c2 - c0) <= 135, "R4 refresh interval", 32'(c2 - c0), 130);
    refresh_slots = 16'd0;
    fc_req = 0;
    expect_frame(16'h0000, "R4 release", c1);
    no_frame(50, "R4 end");

    // R6 half duplex
    full_dup = 0;
    @(negedge clk);
    fc_req = 1;
    @(negedge clk);
    chk(bp_req, "R6 backpressure on", 32'(bp_req), 1);
    no_frame(200, "R6 assert");
    fc_req = 0;
    @(negedge clk);
    chk(!bp_req, "R6 backpressure off", 32'(bp_req), 0);
    no_frame(200, "R6 release");
    full_dup = 1;
    fc_req = 1;
    @(negedge clk);
    chk(!bp_req, "R6 no backpressure in full duplex", 32'(bp_req), 0);
    expect_frame(16'h0777, "R2 after mode change", c0);
    fc_req = 0;
    expect_frame(16'h0000, "R3 after mode change", c0);

    summary();
  end
endmodule